// File: doc/BRIEF.md
# Key-Guarded Fault Injection Controller

This block holds one 32-bit control word that lets software test a peripheral's safety logic. Software can force a single fault onto the redundant shadow copy of any of five guarded control bits, and can force a parity fault onto the configuration. The block then raises the safety status flags that the real checker would raise. Every write must carry a 24-bit access key in the upper field. A write with the wrong key is thrown away whole and changes nothing.

Software can also lock the word for good. The lock holds until a hardware reset, and it is granted only when the peripheral reports no sequence error and the same write asks for no fault at all. The block takes the peripheral's enabled state, its sequence-error flag and a clear strobe for the sticky event flag. It drives one force line per guarded bit, a parity force line, and three status flags.

Top module: `fault_inject_ctrl`

## Requirements
- R1: After a synchronous reset, every force line and every flag is 0, and a read returns 0.
- R2: A write is accepted only when bits 31:8 equal 0x534649. A write with any other key changes no force line, no flag and no lock state.
- R3: While the lock is set, no write changes anything. Only a hardware reset clears the lock.
- R4: Bit 7 of an accepted write sets the lock only when seq_err is 0 and bits 5:0 of that write are all 0. In every other case the lock is left as it was, and the rest of the write still applies.
- R5: In an accepted write, bit i (i = 0..4) loads force line i. A 1 injects the fault on that target and a 0 clears it.
- R6: The mismatch flag is 1 exactly when at least one of force lines 0..4 is active.
- R7: When bit 5 of an accepted write is 1 and periph_en is 0, the parity fault toggles: a fault that is absent is injected, and one that is present is cleared. The parity-error flag follows the parity fault. While periph_en is 1, bit 5 is ignored.
- R8: A read returns the lock in bit 7 and 0 in every other bit. The key and fault fields read as 0.
- R9: The event flag sets on an accepted write that has any of bits 4:0 at 1, or that injects the parity fault. It then stays set until evt_clr is pulsed. When a set and a clear fall in the same cycle, the set wins.
- R10: Every force line and flag changes at the first clock edge after the accepted write, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data: key in 31:8, lock in 7, parity in 5, targets in 4:0 |
| rd_data | output | 32 | Read value of the control word |
| periph_en | input | 1 | Peripheral is enabled |
| seq_err | input | 1 | Peripheral sequence-error flag |
| evt_clr | input | 1 | Clear strobe for the sticky event flag |
| force_o | output | 5 | Fault force lines, one per guarded bit |
| parity_force_o | output | 1 | Parity fault force onto the configuration |
| evt_flag | output | 1 | Sticky safety-event flag |
| mismatch_flag | output | 1 | Redundancy-mismatch flag |
| parity_err_flag | output | 1 | Parity-error flag |

## Verification
The bench sweeps all 64 patterns of bits 5:0 with periph_en both low and high. This exposes a parity bit that sets instead of toggling, and one that acts while the peripheral is running. It also catches a mismatch flag that lags its force lines. Keys that differ from the correct one in a single bit are sent to catch a partial key compare, which would let corrupted writes through. Lock requests are sent with seq_err high, and with each fault bit set in turn. A design that ignored either precondition would lock too early and freeze the following sweeps. A set and a clear of the event flag are also made to collide, which shows a design that gives the clear priority and loses the event.

// File: rtl/fij_pkg.sv
package fij_pkg;

    localparam int REG_W    = 32;
    localparam int KEY_W    = 24;
    localparam int N_TGT    = 5;
    localparam int PAR_BIT  = N_TGT;
    localparam int LOCK_BIT = 7;
    localparam int KEY_LSB  = REG_W - KEY_W;

    localparam logic [KEY_W-1:0] ACCESS_KEY = 24'h534649;

    typedef struct packed {
        logic             key_ok;
        logic             lock_req;
        logic             par_req;
        logic [N_TGT-1:0] tgt;
    } fij_cmd_t;

    function automatic fij_cmd_t fij_unpack(input logic [REG_W-1:0] w);
        fij_cmd_t c;
        c.key_ok   = (w[REG_W-1:KEY_LSB] == ACCESS_KEY);
        c.lock_req = w[LOCK_BIT] && (w[PAR_BIT:0] == '0);
        c.par_req  = w[PAR_BIT];
        c.tgt      = w[N_TGT-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] fij_readback(input logic lock);
        logic [REG_W-1:0] r;
        r           = '0;
        r[LOCK_BIT] = lock;
        return r;
    endfunction

endpackage

// File: rtl/fij_decode.sv
module fij_decode
    import fij_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             lock_q,
    output fij_cmd_t         cmd,
    output logic             accept
);
    always_comb begin
        cmd    = fij_unpack(wr_data);
        accept = wr_en && cmd.key_ok && !lock_q;
    end
endmodule

// File: rtl/fij_lock.sv
module fij_lock
    import fij_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic lock_req,
    input  logic seq_err,
    output logic lock_q
);
    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= 1'b0;
        else if (accept && lock_req && !seq_err)
            lock_q <= 1'b1;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);  // R3

    AST_LOCK_PRECOND: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> ($past(lock_req) && !$past(seq_err) && $past(accept)));  // R4
endmodule

// File: rtl/fij_fault_bank.sv
module fij_fault_bank
    import fij_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             accept,
    input  fij_cmd_t         cmd,
    input  logic             periph_en,
    output logic [N_TGT-1:0] force_q,
    output logic             par_q,
    output logic             evt_set,
    output logic             any_force_nxt
);
    logic [N_TGT-1:0] force_nxt;
    logic             par_toggle;

    for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
        always_comb force_nxt[i] = accept ? cmd.tgt[i] : force_q[i];

        always_ff @(posedge clk) begin
            if (rst)
                force_q[i] <= 1'b0;
            else
                force_q[i] <= force_nxt[i];
        end
    end

    always_comb begin
        par_toggle    = accept && cmd.par_req && !periph_en;
        evt_set       = (accept && (cmd.tgt != '0)) || (par_toggle && !par_q);
        any_force_nxt = |force_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            par_q <= 1'b0;
        else if (par_toggle)
            par_q <= !par_q;
    end

    AST_BADKEY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cmd.key_ok) |=> ($stable(force_q) && $stable(par_q)));  // R2

    AST_PAR_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        periph_en |=> $stable(par_q));  // R7

    AST_TGT_LOAD: assert property (@(posedge clk) disable iff (rst)
        accept |=> (force_q == $past(cmd.tgt)));  // R5
endmodule

// File: rtl/fij_status.sv
module fij_status
    import fij_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_set,
    input  logic             evt_clr,
    input  logic             any_force_nxt,
    input  logic [N_TGT-1:0] force_q,
    output logic             evt_q,
    output logic             mismatch_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q      <= 1'b0;
            mismatch_q <= 1'b0;
        end else begin
            mismatch_q <= any_force_nxt;
            if (evt_set)
                evt_q <= 1'b1;
            else if (evt_clr)
                evt_q <= 1'b0;
        end
    end

    AST_MISMATCH_OR: assert property (@(posedge clk) disable iff (rst)
        mismatch_q == (force_q != '0));  // R6

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (evt_q && !evt_clr) |=> evt_q);  // R9

    AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        evt_set |=> evt_q);  // R9
endmodule

// File: rtl/fault_inject_ctrl.sv
module fault_inject_ctrl
    import fij_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             periph_en,
    input  logic             seq_err,
    input  logic             evt_clr,
    output logic [N_TGT-1:0] force_o,
    output logic             parity_force_o,
    output logic             evt_flag,
    output logic             mismatch_flag,
    output logic             parity_err_flag
);
    fij_cmd_t         cmd;
    logic             accept;
    logic             lock_q;
    logic [N_TGT-1:0] force_q;
    logic             par_q;
    logic             evt_set;
    logic             any_force_nxt;
    logic             evt_q;
    logic             mismatch_q;

    fij_decode u_decode (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .lock_q  (lock_q),
        .cmd     (cmd),
        .accept  (accept)
    );

    fij_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .lock_req (cmd.lock_req),
        .seq_err  (seq_err),
        .lock_q   (lock_q)
    );

    fij_fault_bank u_bank (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .accept        (accept),
        .cmd           (cmd),
        .periph_en     (periph_en),
        .force_q       (force_q),
        .par_q         (par_q),
        .evt_set       (evt_set),
        .any_force_nxt (any_force_nxt)
    );

    fij_status u_status (
        .clk           (clk),
        .rst           (rst),
        .evt_set       (evt_set),
        .evt_clr       (evt_clr),
        .any_force_nxt (any_force_nxt),
        .force_q       (force_q),
        .evt_q         (evt_q),
        .mismatch_q    (mismatch_q)
    );

    always_comb begin
        rd_data         = fij_readback(lock_q);
        force_o         = force_q;
        parity_force_o  = par_q;
        parity_err_flag = par_q;
        evt_flag        = evt_q;
        mismatch_flag   = mismatch_q;
    end

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> ($stable(force_o) && $stable(parity_force_o)));  // R3

    AST_READ_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~(32'h1 << LOCK_BIT)) == '0);  // R8
endmodule

// File: tb/fault_inject_ctrl_tb.sv
module fault_inject_ctrl_tb;
    localparam logic [23:0] KEY = 24'h534649;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        periph_en = 1'b0;
    logic        seq_err = 1'b0;
    logic        evt_clr = 1'b0;
    logic [4:0]  force_o;
    logic        parity_force_o, evt_flag, mismatch_flag, parity_err_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [4:0] m_force;
    logic       m_par, m_lock, m_evt;

    always #10 clk = ~clk;

    fault_inject_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .periph_en(periph_en), .seq_err(seq_err), .evt_clr(evt_clr),
        .force_o(force_o), .parity_force_o(parity_force_o), .evt_flag(evt_flag),
        .mismatch_flag(mismatch_flag), .parity_err_flag(parity_err_flag)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, "/R5"}, "force_o", 32'(force_o), 32'(m_force));
        chk({tag, "/R6"}, "mismatch", 32'(mismatch_flag), 32'(m_force != 5'd0));
        chk({tag, "/R7"}, "parity_force", 32'(parity_force_o), 32'(m_par));
        chk({tag, "/R7"}, "parity_err", 32'(parity_err_flag), 32'(m_par));
        chk({tag, "/R9"}, "evt", 32'(evt_flag), 32'(m_evt));
        chk({tag, "/R8"}, "rd_data", rd_data, 32'(m_lock) << 7);
    endtask

    task automatic model_reset();
        m_force = '0; m_par = 1'b0; m_lock = 1'b0; m_evt = 1'b0;
    endtask

    task automatic hw_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
    endtask

    task automatic do_wr(input logic [31:0] d, input logic pe, input logic se,
                         input logic clr, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; periph_en = pe; seq_err = se; evt_clr = clr;
        #1 check_all({tag, "/R10-pre"});
        @(negedge clk);
        wr_en = 1'b0; evt_clr = 1'b0;
        if (clr) m_evt = 1'b0;
        if (!m_lock && d[31:8] == KEY) begin
            if (d[4:0] != 5'd0) m_evt = 1'b1;
            m_force = d[4:0];
            if (d[5] && !pe) begin
                m_par = !m_par;
                if (m_par) m_evt = 1'b1;
            end
            if (d[7] && !se && d[5:0] == 6'd0) m_lock = 1'b1;
        end
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_all("R1");

        // R5 R6 R7 R9: sweep every low-field pattern in both peripheral states
        for (int pe = 0; pe < 2; pe++) begin
            for (int v = 0; v < 64; v++) begin
                do_wr({KEY, 2'b00, 6'(v)}, 1'(pe), 1'b0, (v % 7) == 3, "R5sweep");
            end
        end

        // R9: clear then collision of set and clear
        do_wr({KEY, 8'h00}, 1'b0, 1'b0, 1'b1, "R9clr");
        do_wr({KEY, 8'h04}, 1'b0, 1'b0, 1'b1, "R9collide");
        do_wr({KEY, 8'h00}, 1'b0, 1'b0, 1'b0, "R9hold");

        // R2: single-bit key corruptions and zero key
        do_wr({KEY, 8'h13}, 1'b0, 1'b0, 1'b1, "R2setup");
        do_wr({24'h0, 8'h2C}, 1'b0, 1'b0, 1'b0, "R2zero");
        for (int k = 0; k < 24; k++) begin
            do_wr({KEY ^ (24'h1 << k), 8'hA0 | 8'(k % 32)}, 1'b0, 1'b0, 1'b0, "R2flip");
        end
        do_wr({KEY ^ 24'h1, 8'h80}, 1'b0, 1'b0, 1'b0, "R2lock");

        // R4: refused lock requests
        do_wr({KEY, 8'h80}, 1'b0, 1'b1, 1'b0, "R4seqerr");
        for (int b = 0; b < 6; b++) begin
            do_wr({KEY, 8'h80 | (8'h1 << b)}, 1'b0, 1'b0, 1'b0, "R4fault");
        end
        do_wr({KEY, 8'h00}, 1'b0, 1'b0, 1'b1, "R4tidy");
        do_wr({KEY, 8'h03}, 1'b0, 1'b0, 1'b0, "R4pre");
        do_wr({KEY, 8'h80}, 1'b1, 1'b0, 1'b0, "R4grant");
        chk("R4", "lock set", 32'(rd_data[7]), 32'd1);

        // R3: locked word ignores every write
        do_wr({KEY, 8'h1F}, 1'b0, 1'b0, 1'b0, "R3tgt");
        do_wr({KEY, 8'h20}, 1'b0, 1'b0, 1'b0, "R3par");
        do_wr({KEY, 8'h00}, 1'b0, 1'b0, 1'b1, "R3clr");
        do_wr({KEY, 8'h3F}, 1'b0, 1'b0, 1'b0, "R3all");
        hw_reset();
        check_all("R3reset");
        chk("R3", "lock cleared by reset", 32'(rd_data[7]), 32'd0);
        do_wr({KEY, 8'h21}, 1'b0, 1'b0, 1'b0, "R3after");
        do_wr({KEY, 8'h20}, 1'b0, 1'b0, 1'b0, "R7clear");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule